// File: doc/BRIEF.md
# Mode Register Entry Sequencer

This block sits on the device side of an asynchronous pseudo-static memory and watches the host's access stream. It counts bus cycles on the rising edge of chip-enable. It looks for a fixed prefix to the highest word address: one read followed by two writes. Once the prefix has matched, the next three cycles are committed. The fourth access chooses between programming the internal mode register and reading it back. The fifth and sixth accesses then carry or return the two 16-bit halves of that register.

The memory array, burst behaviour and the meaning of the mode fields lie outside the block. It only flags when the array must ignore the current access (`array_inhibit`). It also drives read-back data onto its own output path. The bus inputs are assumed to be already synchronous to `clk`. A cycle ends in the clock cycle where `ce_n` is first seen high after being low. The address, data and type of the access are taken in that clock cycle.

Top module: `modereg_entry_seq`

## Requirements
- R1: After reset, `seq_busy`, `seq_done`, `mode_valid`, `array_inhibit` and `rd_drive` are all 0.
- R2: A bus cycle ends on a `ce_n` low-to-high transition. It counts as a read if `oe_n` was low while `ce_n` was low and `we_n` stayed high. It counts as a write if `we_n` was low at any point while `ce_n` was low. A cycle with neither strobe is neither a read nor a write.
- R3: A read to address 0x3FFFFF, then a write to it, then another write to it, advances the prefix. `seq_busy` goes high after the first matching cycle.
- R4: During the prefix, any cycle that does not match returns the block to idle (`seq_busy` low). This covers another address, the wrong type, or a cycle with no strobe. The exception is a read to 0x3FFFFF, which restarts the prefix at its first step.
- R5: The fourth cycle is counted whatever its address or type. Data bit 0 of that cycle selects set mode (1) or read-back mode (0).
- R6: In set mode, bits 15:0 of the fifth cycle's data form `mode_reg[15:0]` and bits 15:0 of the sixth cycle's data form `mode_reg[31:16]`. Higher data bits are ignored. `mode_reg` changes only at the end of the sixth cycle, and `mode_valid` rises then and stays high.
- R7: In read-back mode, `rd_drive` is high while `ce_n` and `oe_n` are low and `we_n` is high. During the fifth cycle, `rd_data` is `{16'h0, mode_reg[15:0]}`. During the sixth cycle, it is `{16'h0, mode_reg[31:16]}`. `mode_reg` is left unchanged.
- R8: `seq_done` is a one-clock pulse in the clock after the sixth cycle ends, in either mode. `seq_busy` falls at the same edge.
- R9: `array_inhibit` is high from the end of the third cycle until the end of the sixth. It is never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip-enable, active low |
| oe_n | input | 1 | Output-enable, active low |
| we_n | input | 1 | Write-enable, active low |
| addr | input | 22 | Word address |
| din | input | 32 | Write data from host |
| mode_reg | output | 32 | Mode register contents |
| mode_valid | output | 1 | Mode register has been set at least once |
| rd_data | output | 32 | Read-back data |
| rd_drive | output | 1 | Read-back data is to be driven onto the bus |
| array_inhibit | output | 1 | Current access must not touch the array |
| seq_busy | output | 1 | Entry sequence in progress |
| seq_done | output | 1 | One-clock pulse when the sequence completes |

## Verification
A sequencer stuck in the wrong stage shows at the ports no later than the end of the next bus cycle. It appears as a `seq_busy` level that disagrees with the number of matched cycles. It can also appear as `array_inhibit` rising a cycle early or late. A mode-select bit latched wrongly shows up in the fifth cycle, either as `rd_drive` staying low or as `mode_reg` changing when it should not. Swapped or truncated halves become visible in the `mode_reg` value right after `seq_done`, and in the read-back value of the following sequence.

// File: rtl/modereg_pkg.sv
package modereg_pkg;
  // Each state names the bus cycle the sequencer is waiting for.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for cycle 1 (read, top)
    ST_P1   = 3'd1,  // waiting for cycle 2 (write, top)
    ST_P2   = 3'd2,  // waiting for cycle 3 (write, top)
    ST_SEL  = 3'd3,  // waiting for cycle 4 (select, committed)
    ST_C5   = 3'd4,  // waiting for cycle 5
    ST_C6   = 3'd5   // waiting for cycle 6
  } seq_state_t;
endpackage

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_end,
  output logic              cyc_rd,
  output logic              cyc_wr,
  output logic              cyc_top
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic ce_q;
  logic saw_oe_q, saw_oe_d;
  logic saw_we_q, saw_we_d;

  always_comb begin
    cyc_end  = ce_n & ~ce_q;
    saw_oe_d = saw_oe_q;
    saw_we_d = saw_we_q;
    if (cyc_end) begin
      saw_oe_d = 1'b0;
      saw_we_d = 1'b0;
    end else if (!ce_n) begin
      saw_oe_d = saw_oe_q | ~oe_n;
      saw_we_d = saw_we_q | ~we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      saw_oe_q <= 1'b0;
      saw_we_q <= 1'b0;
    end else begin
      ce_q     <= ce_n;
      saw_oe_q <= saw_oe_d;
      saw_we_q <= saw_we_d;
    end
  end

  assign cyc_wr  = saw_we_q;
  assign cyc_rd  = saw_oe_q & ~saw_we_q;
  assign cyc_top = (addr == TOP_ADDR);
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import modereg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_end,
  input  logic       cyc_rd,
  input  logic       cyc_wr,
  input  logic       cyc_top,
  input  logic       sel_bit,
  output seq_state_t state,
  output logic       op_set,
  output logic       lo_capture,
  output logic       hi_commit,
  output logic       done
);
  seq_state_t st_q, st_d;
  logic       op_set_q, op_set_d;
  logic       done_q, done_d;
  logic       top_rd, top_wr;

  assign top_rd = cyc_rd & cyc_top;
  assign top_wr = cyc_wr & cyc_top;

  always_comb begin
    st_d     = st_q;
    op_set_d = op_set_q;
    done_d   = 1'b0;
    if (cyc_end) begin
      unique case (st_q)
        ST_IDLE: st_d = top_rd ? ST_P1 : ST_IDLE;
        ST_P1:   st_d = top_wr ? ST_P2 : (top_rd ? ST_P1 : ST_IDLE);
        ST_P2:   st_d = top_wr ? ST_SEL : (top_rd ? ST_P1 : ST_IDLE);
        ST_SEL: begin
          st_d     = ST_C5;
          op_set_d = sel_bit;
        end
        ST_C5:   st_d = ST_C6;
        ST_C6: begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_set_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      op_set_q <= op_set_d;
      done_q   <= done_d;
    end
  end

  assign state      = st_q;
  assign op_set     = op_set_q;
  assign done       = done_q;
  assign lo_capture = cyc_end & op_set_q & (st_q == ST_C5);
  assign hi_commit  = cyc_end & op_set_q & (st_q == ST_C6);
endmodule

// File: rtl/mode_store.sv
module mode_store #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_capture,
  input  logic                hi_commit,
  input  logic [HALF_W-1:0]   code_in,
  output logic [2*HALF_W-1:0] mode_reg,
  output logic                mode_valid
);
  logic [HALF_W-1:0]   stage_lo_q;
  logic [2*HALF_W-1:0] mreg_q;
  logic                valid_q;

  // Data holders carry no reset: contents are unknown until first set.
  always_ff @(posedge clk) begin
    if (lo_capture) stage_lo_q <= code_in;
  end

  always_ff @(posedge clk) begin
    if (hi_commit) mreg_q <= {code_in, stage_lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (hi_commit) valid_q <= 1'b1;
  end

  assign mode_reg   = mreg_q;
  assign mode_valid = valid_q;
endmodule

// File: rtl/modereg_entry_seq.sv
module modereg_entry_seq
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32,
  parameter int CODE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic [2*CODE_W-1:0] mode_reg,
  output logic                mode_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_drive,
  output logic                array_inhibit,
  output logic                seq_busy,
  output logic                seq_done
);
  localparam int MODE_W = 2 * CODE_W;

  logic       cyc_end, cyc_rd, cyc_wr, cyc_top;
  logic       op_set, lo_capture, hi_commit;
  seq_state_t state;

  bus_cycle_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .cyc_end (cyc_end),
    .cyc_rd  (cyc_rd),
    .cyc_wr  (cyc_wr),
    .cyc_top (cyc_top)
  );

  entry_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_end    (cyc_end),
    .cyc_rd     (cyc_rd),
    .cyc_wr     (cyc_wr),
    .cyc_top    (cyc_top),
    .sel_bit    (din[0]),
    .state      (state),
    .op_set     (op_set),
    .lo_capture (lo_capture),
    .hi_commit  (hi_commit),
    .done       (seq_done)
  );

  mode_store #(.HALF_W(CODE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_capture (lo_capture),
    .hi_commit  (hi_commit),
    .code_in    (din[CODE_W-1:0]),
    .mode_reg   (mode_reg),
    .mode_valid (mode_valid)
  );

  logic rb_phase;
  assign rb_phase = ~op_set & ((state == ST_C5) | (state == ST_C6));

  always_comb begin
    rd_data = '0;
    if (state == ST_C6) rd_data[CODE_W-1:0] = mode_reg[MODE_W-1:CODE_W];
    else                rd_data[CODE_W-1:0] = mode_reg[CODE_W-1:0];
  end

  assign rd_drive      = rb_phase & ~ce_n & ~oe_n & we_n;
  assign seq_busy      = (state != ST_IDLE);
  assign array_inhibit = (state == ST_SEL) | (state == ST_C5) | (state == ST_C6);
endmodule

// File: rtl/modereg_entry_seq_chk.sv
module modereg_entry_seq_chk #(
  parameter int MODE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              seq_done,
  input logic              seq_busy,
  input logic              mode_valid,
  input logic [MODE_W-1:0] mode_reg,
  input logic              rd_drive,
  input logic              array_inhibit
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy); // R8
  AST_DONE_AFTER_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(ce_n)); // R2
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> mode_valid); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && !seq_done) |-> $stable(mode_reg)); // R6
  AST_DRIVE_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (array_inhibit && !ce_n)); // R7
  AST_INHIBIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    array_inhibit |-> seq_busy); // R9
endmodule

bind modereg_entry_seq modereg_entry_seq_chk #(.MODE_W(2*CODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ce_n          (ce_n),
  .seq_done      (seq_done),
  .seq_busy      (seq_busy),
  .mode_valid    (mode_valid),
  .mode_reg      (mode_reg),
  .rd_drive      (rd_drive),
  .array_inhibit (array_inhibit)
);

// File: tb/modereg_entry_seq_test.sv
module modereg_entry_seq_test;
  logic        clk;
  logic        rst_n;
  logic        ce_n, oe_n, we_n;
  logic [21:0] addr;
  logic [31:0] din;
  logic [31:0] mode_reg;
  logic        mode_valid;
  logic [31:0] rd_data;
  logic        rd_drive, array_inhibit, seq_busy, seq_done;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  localparam logic [21:0] TOP = 22'h3FFFFF;
  localparam int K_RD = 0, K_WR = 1, K_NONE = 2;

  // row: kind[61:60] addr[59:38] data[37:6] busy[5] done[4] req[3:0]
  localparam int NROW = 13;
  localparam logic [61:0] TBL [0:NROW-1] = '{
    {2'd0, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3}, // R3 cycle 1
    {2'd1, 22'h000010, 32'h0,        1'b0, 1'b0, 4'd4}, // R4 wrong address
    {2'd0, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
    {2'd1, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
    {2'd0, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd4}, // R4 top read restarts
    {2'd2, 22'h3FFFFF, 32'h0,        1'b0, 1'b0, 4'd2}, // R2 no strobe
    {2'd0, 22'h3FFFFE, 32'h0,        1'b0, 1'b0, 4'd4}, // R4 wrong address
    {2'd0, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
    {2'd1, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
    {2'd1, 22'h3FFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
    {2'd0, 22'h000000, 32'h1,        1'b1, 1'b0, 4'd5}, // R5 any addr/type, set
    {2'd1, 22'h3FFFFF, 32'h0000BEEF, 1'b1, 1'b0, 4'd6},
    {2'd1, 22'h3FFFFF, 32'h00001234, 1'b0, 1'b1, 4'd8}  // R8 done pulse
  };

  modereg_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .mode_reg(mode_reg), .mode_valid(mode_valid),
    .rd_data(rd_data), .rd_drive(rd_drive), .array_inhibit(array_inhibit),
    .seq_busy(seq_busy), .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; samples read-back outputs while the strobes are active.
  task automatic acc(input int kind, input logic [21:0] a, input logic [31:0] d,
                     output logic [31:0] mid_data, output logic mid_drv);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0;
    oe_n = (kind == K_RD) ? 1'b0 : 1'b1;
    we_n = (kind == K_WR) ? 1'b0 : 1'b1;
    @(negedge clk);
    mid_data = rd_data; mid_drv = rd_drive;
    @(negedge clk);
    oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix();
    logic [31:0] md; logic mv;
    acc(K_RD, TOP, 32'h0, md, mv);
    acc(K_WR, TOP, 32'h0, md, mv);
    acc(K_WR, TOP, 32'h0, md, mv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] md; logic mv;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy",    {31'd0, seq_busy},      32'd0);
    chk("R1 done",    {31'd0, seq_done},      32'd0);
    chk("R1 valid",   {31'd0, mode_valid},    32'd0);
    chk("R1 inhibit", {31'd0, array_inhibit}, 32'd0);
    chk("R1 drive",   {31'd0, rd_drive},      32'd0);

    for (int i = 0; i < NROW; i++) begin
      logic [61:0] r;
      string tag;
      r = TBL[i];
      tag = $sformatf("R%0d row %0d", r[3:0], i);
      acc(int'(r[61:60]), r[59:38], r[37:6], md, mv);
      chk({tag, " busy"}, {31'd0, seq_busy}, {31'd0, r[5]});
      chk({tag, " done"}, {31'd0, seq_done}, {31'd0, r[4]});
    end
    @(negedge clk);
    chk("R8 done clears", {31'd0, seq_done}, 32'd0);
    chk("R6 mode_reg set", mode_reg, 32'h1234BEEF);
    chk("R6 valid",        {31'd0, mode_valid}, 32'd1);

    // R7 read-back; R9 inhibit after prefix
    prefix();
    chk("R9 inhibit after cycle 3", {31'd0, array_inhibit}, 32'd1);
    acc(K_WR, TOP, 32'h0, md, mv);
    acc(K_RD, TOP, 32'h0, md, mv);
    chk("R7 cycle5 data", md, 32'h0000BEEF);
    chk("R7 cycle5 drive", {31'd0, mv}, 32'd1);
    acc(K_RD, TOP, 32'h0, md, mv);
    chk("R7 cycle6 data", md, 32'h00001234);
    chk("R7 cycle6 drive", {31'd0, mv}, 32'd1);
    chk("R8 done after readback", {31'd0, seq_done}, 32'd1);
    chk("R7 mode_reg kept", mode_reg, 32'h1234BEEF);
    chk("R9 inhibit off", {31'd0, array_inhibit}, 32'd0);

    // R5 select cycle with no strobe; R6 upper data bits ignored
    prefix();
    acc(K_NONE, 22'h000123, 32'h00000001, md, mv);
    chk("R5 committed", {31'd0, seq_busy}, 32'd1);
    acc(K_WR, TOP, 32'hABCD0055, md, mv);
    chk("R6 not yet updated", mode_reg, 32'h1234BEEF);
    acc(K_WR, TOP, 32'hFFFF00AA, md, mv);
    chk("R6 halves", mode_reg, 32'h00AA0055);

    // R7 read strobe in set-mode cycle 5 must not drive
    prefix();
    acc(K_WR, TOP, 32'h1, md, mv);
    acc(K_RD, TOP, 32'h0000_0077, md, mv);
    chk("R7 no drive in set mode", {31'd0, mv}, 32'd0);
    acc(K_WR, TOP, 32'h0000_0066, md, mv);
    chk("R6 read strobe in cycle5 still captures", mode_reg, 32'h00660077);

    // R1 reset mid-sequence
    acc(K_RD, TOP, 32'h0, md, mv);
    acc(K_WR, TOP, 32'h0, md, mv);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, seq_busy}, 32'd0);
    chk("R1 valid after reset", {31'd0, mode_valid}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule